// File: doc/BRIEF.md
# Block Erase and Blank-Check Sequencer

This block runs one erase or blank-check job on a single memory block and keeps the status bits that report on that job. A start pulse carries the block address and the job kind. An erase job moves through three timed phases: conditioning, then erasing, then verifying. A blank-check job is one timed scan phase. Cycle counters stand in for the real cell behaviour. A fault input, sampled in the last cycle of the job, stands for a failed verify or a block that is not blank.

An erase job can be paused and later continued. A pause request is stored and takes effect only when the current phase ends. A continue request is refused while a nested program job is still pending. The error bits (failure, supply, locked block) stay set until an explicit clear, and they are kept across a pause and its continuation. Reset drops any job at once, and the block's contents are then undefined.

The states are IDLE, COND, ERASE, VERIFY, BCHK and SUSP. Transitions:
- start (accepted): IDLE to COND for an erase, or IDLE to BCHK for a blank check.
- phase end: COND to ERASE and ERASE to VERIFY.
- pause at phase end: COND or ERASE goes to SUSP.
- completion: VERIFY to IDLE and BCHK to IDLE.
- supply loss: any busy state to IDLE.
- continue: SUSP back to the stored next phase.

Top module: `erase_sequencer`

## Requirements
- R1: After reset, whether at power-up or in the middle of a job, `status_o` is 0x80 and `phase_o` is 0. Any job in progress is dropped.
- R2: An accepted erase start clears status bit 7 and stores the block address on `blk_o`. `phase_o` then reads 1 (COND) for COND_CYC cycles, 2 (ERASE) for ERASE_CYC cycles and 3 (VERIFY) for VERIFY_CYC cycles, and then returns to 0 with status bit 7 set. With the default parameters the job takes 16 clock edges.
- R3: A start while `blk_locked_i` is high sets status bit 1, and no job begins: `phase_o` stays 0 and bit 7 stays 1. This check takes priority over the supply check.
- R4: A start while `supply_ok_i` is low, or a low `supply_ok_i` during any busy phase, sets status bit 3 and returns the block to IDLE with bit 7 set.
- R5: A pause request during COND or ERASE is stored. The pause takes effect at the end of that phase: `phase_o` becomes 5 and status bits 7 and 6 are both 1. A pause request during VERIFY is dropped, because the job completes at the end of that phase.
- R6: An accepted continue clears status bits 7 and 6 in the next cycle and enters the phase that follows the interrupted one, with its full length.
- R7: A continue request while `prog_pend_i` is high is ignored, and the block stays paused.
- R8: If `fault_i` is high in the last cycle of VERIFY or BCHK, status bit 5 is set when the job completes.
- R9: A blank-check job shows `phase_o` = 4 for BCHK_CYC cycles (6 by default). Pause and continue requests have no effect on it.
- R10: Bits 5, 3 and 1 stay set until `clr_err_i` is applied, including across a pause and continue. If a set and a clear fall on the same cycle, the set wins.
- R11: A start is ignored unless the block is in IDLE. The running job's address and length do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a job |
| op_i | input | 1 | Job kind: 0 erase, 1 blank check |
| blk_addr_i | input | BLK_W | Target block address |
| blk_locked_i | input | 1 | Target block is locked |
| supply_ok_i | input | 1 | Programming supply is in range |
| fault_i | input | 1 | Fault injection for verify or blank check |
| susp_req_i | input | 1 | Pause request pulse |
| resume_req_i | input | 1 | Continue request pulse |
| prog_pend_i | input | 1 | A nested program job is still pending |
| clr_err_i | input | 1 | Clear error status bits |
| status_o | output | 8 | Status: bit 7 ready, bit 6 paused, bit 5 fail, bit 3 supply error, bit 1 locked abort |
| phase_o | output | 3 | Current state code (0 IDLE to 5 SUSP) |
| blk_o | output | BLK_W | Address of the accepted job |

## Verification
Two pairs of events can fall in the same cycle. The first is an error bit being set and `clr_err_i` arriving. The bench provokes this by giving a locked-block start together with a clear, and it expects status 0x82 afterwards. The second is a pause request and the phase end it waits for. The bench issues pause requests in an early COND cycle, in the last VERIFY cycles and during a blank check. It then judges from the `phase_o` and `status_o` timeline whether the pause landed exactly at the phase end or was dropped.

// File: rtl/esq_pkg.sv
package esq_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_COND   = 3'd1,
        S_ERASE  = 3'd2,
        S_VERIFY = 3'd3,
        S_BCHK   = 3'd4,
        S_SUSP   = 3'd5
    } esq_state_e;

    localparam int SR_READY = 7;
    localparam int SR_PAUSE = 6;
    localparam int SR_FAIL  = 5;
    localparam int SR_VPP   = 3;
    localparam int SR_LOCK  = 1;
endpackage

// File: rtl/esq_phase_timer.sv
module esq_phase_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          last
);
    localparam logic [CW-1:0] ONE = 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (run)   cnt_q <= cnt_q + ONE;
    end

    assign last = run && (cnt_q == limit - ONE);

    // R2: the count never runs past the length of the current phase
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));
endmodule

// File: rtl/esq_err_bits.sv
module esq_err_bits (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_fail,
    input  logic       set_vpp,
    input  logic       set_lock,
    output logic [2:0] err
);
    logic [2:0] set_v;
    assign set_v = {set_fail, set_vpp, set_lock};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err <= '0;
        else        err <= (err & ~{3{clr}}) | set_v;
    end

    for (genvar gi = 0; gi < 3; gi++) begin : g_chk
        // R10: a set error bit survives every cycle without a clear
        p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (err[gi] && !clr) |=> err[gi]);
        // R10: a set request wins over a clear in the same cycle
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[gi] |=> err[gi]);
    end
endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
    import esq_pkg::*;
#(
    parameter int BLK_W      = 6,
    parameter int COND_CYC   = 4,
    parameter int ERASE_CYC  = 8,
    parameter int VERIFY_CYC = 4,
    parameter int BCHK_CYC   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic [BLK_W-1:0] blk_addr_i,
    input  logic             blk_locked_i,
    input  logic             supply_ok_i,
    input  logic             fault_i,
    input  logic             susp_req_i,
    input  logic             resume_req_i,
    input  logic             prog_pend_i,
    input  logic             clr_err_i,
    output logic [7:0]       status_o,
    output logic [2:0]       phase_o,
    output logic [BLK_W-1:0] blk_o
);
    localparam int CW = $clog2(COND_CYC + ERASE_CYC + VERIFY_CYC + BCHK_CYC + 1);

    esq_state_e state_q, state_n, ret_q, ret_n;
    logic       pend_q, pend_n;
    logic       t_clr, t_run, t_last;
    logic [CW-1:0] t_limit;
    logic       set_fail, set_vpp, set_lock;
    logic [2:0] err;
    logic       accept;

    assign accept = (state_q == S_IDLE) && start_i && !blk_locked_i && supply_ok_i;
    assign t_run  = (state_q != S_IDLE) && (state_q != S_SUSP);

    always_comb begin
        unique case (state_q)
            S_COND:   t_limit = CW'(COND_CYC);
            S_ERASE:  t_limit = CW'(ERASE_CYC);
            S_VERIFY: t_limit = CW'(VERIFY_CYC);
            S_BCHK:   t_limit = CW'(BCHK_CYC);
            default:  t_limit = CW'(COND_CYC);
        endcase
    end

    esq_phase_timer #(.CW(CW)) timer_i (
        .clk(clk), .rst_n(rst_n), .clear(t_clr), .run(t_run),
        .limit(t_limit), .last(t_last)
    );

    esq_err_bits errs_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_err_i),
        .set_fail(set_fail), .set_vpp(set_vpp), .set_lock(set_lock), .err(err)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ret_q   <= S_IDLE;
            pend_q  <= 1'b0;
            blk_o   <= '0;
        end else begin
            state_q <= state_n;
            ret_q   <= ret_n;
            pend_q  <= pend_n;
            if (accept) blk_o <= blk_addr_i;
        end
    end

    // next state
    always_comb begin
        state_n  = state_q;
        ret_n    = ret_q;
        pend_n   = pend_q;
        t_clr    = 1'b0;
        set_fail = 1'b0;
        set_vpp  = 1'b0;
        set_lock = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (blk_locked_i)      set_lock = 1'b1;
                    else if (!supply_ok_i) set_vpp  = 1'b1;
                    else begin
                        state_n = op_i ? S_BCHK : S_COND;
                        pend_n  = 1'b0;
                        t_clr   = 1'b1;
                    end
                end
            end
            S_COND, S_ERASE, S_VERIFY: begin
                if (!supply_ok_i) begin
                    set_vpp = 1'b1;
                    state_n = S_IDLE;
                    pend_n  = 1'b0;
                    t_clr   = 1'b1;
                end else begin
                    if (susp_req_i) pend_n = 1'b1;
                    if (t_last) begin
                        t_clr = 1'b1;
                        if (state_q == S_VERIFY) begin
                            set_fail = fault_i;
                            state_n  = S_IDLE;
                            pend_n   = 1'b0;
                        end else if (pend_q || susp_req_i) begin
                            state_n = S_SUSP;
                            ret_n   = (state_q == S_COND) ? S_ERASE : S_VERIFY;
                            pend_n  = 1'b0;
                        end else begin
                            state_n = (state_q == S_COND) ? S_ERASE : S_VERIFY;
                        end
                    end
                end
            end
            S_BCHK: begin
                if (!supply_ok_i) begin
                    set_vpp = 1'b1;
                    state_n = S_IDLE;
                    t_clr   = 1'b1;
                end else if (t_last) begin
                    set_fail = fault_i;
                    state_n  = S_IDLE;
                    t_clr    = 1'b1;
                end
            end
            S_SUSP: begin
                if (resume_req_i && !prog_pend_i) begin
                    state_n = ret_q;
                    t_clr   = 1'b1;
                end
            end
            default: begin
                state_n = S_IDLE;
                t_clr   = 1'b1;
            end
        endcase
    end

    // outputs
    always_comb begin
        status_o           = '0;
        status_o[SR_READY] = (state_q == S_IDLE) || (state_q == S_SUSP);
        status_o[SR_PAUSE] = (state_q == S_SUSP);
        status_o[SR_FAIL]  = err[2];
        status_o[SR_VPP]   = err[1];
        status_o[SR_LOCK]  = err[0];
        phase_o            = state_q;
    end

    // R5: a pause only lands on a phase end
    p_susp_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_SUSP && state_n == S_SUSP) |-> t_last);
    // R7: no continue while a nested program is pending
    p_resume_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SUSP && prog_pend_i) |=> (state_q == S_SUSP));
    // R9: a blank check never pauses
    p_bchk_nosusp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BCHK) |=> (state_q != S_SUSP));
    // R3: a locked start leaves the block idle and flags the abort
    p_lock_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && blk_locked_i) |=> (state_q == S_IDLE && status_o[SR_LOCK]));
endmodule

// File: tb/erase_sequencer_tb_top.sv
`timescale 1ns/1ps
module erase_sequencer_tb_top;
    localparam int BLK_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, op = 0, locked = 0, supply = 1, fault = 0;
    logic susp = 0, resume = 0, ppend = 0, clr = 0;
    logic [BLK_W-1:0] addr = '0;
    logic [7:0] status;
    logic [2:0] phase;
    logic [BLK_W-1:0] blk;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    erase_sequencer #(.BLK_W(BLK_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .blk_addr_i(addr),
        .blk_locked_i(locked), .supply_ok_i(supply), .fault_i(fault),
        .susp_req_i(susp), .resume_req_i(resume), .prog_pend_i(ppend),
        .clr_err_i(clr), .status_o(status), .phase_o(phase), .blk_o(blk)
    );

    // {op, locked, supply_ok, fault, expected status}
    localparam logic [11:0] VEC [8] = '{
        {4'b0010, 8'h80}, {4'b0011, 8'hA0}, {4'b0110, 8'h82}, {4'b0000, 8'h88},
        {4'b1010, 8'h80}, {4'b1011, 8'hA0}, {4'b1110, 8'h82}, {4'b0100, 8'h82}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic go(input logic o, input logic [BLK_W-1:0] a);
        op = o; addr = a; start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic clear_err();
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick();
        chk("R1 reset status", status, 8'h80);
        chk("R1 reset phase", {5'd0, phase}, 8'd0);
        rst_n = 1'b1;
        tick();

        // table of jobs: R2 R3 R4 R8 R9
        for (int i = 0; i < 8; i++) begin
            logic [11:0] v;
            v = VEC[i];
            locked = v[10]; supply = v[9]; fault = v[8];
            go(v[11], BLK_W'(i));
            if (v[1] | v[3]) chk("R3/R4 abort at start", status, v[7:0]);
            else begin
                chk("R2/R9 busy", {7'd0, status[7]}, 8'd0);
                chk("R2/R9 first phase", {5'd0, phase}, v[11] ? 8'd4 : 8'd1);
            end
            repeat (v[11] ? 6 : 16) tick();
            chk("R8 table end status", status, v[7:0]);
            chk("R8 table end phase", {5'd0, phase}, 8'd0);
            locked = 0; supply = 1; fault = 0;
            clear_err();
        end

        // R2 timeline, R11 start ignored while busy
        go(1'b0, 6'd5);
        for (int k = 0; k < 16; k++) begin
            chk("R2 timeline", {5'd0, phase}, (k < 4) ? 8'd1 : (k < 12) ? 8'd2 : 8'd3);
            if (k == 6) begin op = 1; addr = 6'd9; start = 1; end
            else start = 0;
            tick();
        end
        chk("R2 done status", status, 8'h80);
        chk("R11 address kept", {2'd0, blk}, 8'd5);

        // R4 supply loss during ERASE
        go(1'b0, 6'd3);
        repeat (5) tick();
        supply = 0; tick(); supply = 1;
        chk("R4 supply drop status", status, 8'h88);
        chk("R4 supply drop phase", {5'd0, phase}, 8'd0);
        clear_err();

        // R5 R6 R7 pause and continue
        go(1'b0, 6'd7);
        tick();
        susp = 1; tick(); susp = 0;
        chk("R5 pause waits for phase end", {5'd0, phase}, 8'd1);
        tick();
        chk("R5 still in COND", status, 8'h00);
        tick();
        chk("R5 paused status", status, 8'hC0);
        chk("R5 paused phase", {5'd0, phase}, 8'd5);
        repeat (5) tick();
        chk("R5 stays paused", status, 8'hC0);
        ppend = 1; resume = 1; tick(); resume = 0;
        chk("R7 continue refused", status, 8'hC0);
        chk("R7 still paused phase", {5'd0, phase}, 8'd5);
        ppend = 0; resume = 1; tick(); resume = 0;
        chk("R6 continue status", status, 8'h00);
        chk("R6 continue phase", {5'd0, phase}, 8'd2);
        repeat (11) tick();
        chk("R6 verify after full erase", {5'd0, phase}, 8'd3);
        tick();
        chk("R6 completion", status, 8'h80);

        // R10 sticky fail across pause and continue
        fault = 1; go(1'b0, 6'd1); repeat (16) tick(); fault = 0;
        chk("R8 erase fail", status, 8'hA0);
        go(1'b0, 6'd2);
        susp = 1; tick(); susp = 0;
        repeat (3) tick();
        chk("R10 fail kept while paused", status, 8'hE0);
        resume = 1; tick(); resume = 0;
        chk("R10 fail kept after continue", status, 8'h20);
        repeat (12) tick();
        chk("R10 fail kept at end", status, 8'hA0);
        clear_err();
        chk("R10 clear", status, 8'h80);

        // R9 blank check ignores pause and continue
        go(1'b1, 6'd4);
        susp = 1; tick(); susp = 0;
        resume = 1; tick(); resume = 0;
        for (int k = 2; k < 6; k++) begin
            chk("R9 blank check phase", {5'd0, phase}, 8'd4);
            tick();
        end
        chk("R9 blank check done", status, 8'h80);

        // R5 pause request during VERIFY is dropped
        go(1'b0, 6'd6);
        repeat (13) tick();
        susp = 1; tick(); susp = 0;
        repeat (2) tick();
        chk("R5 verify pause dropped", status, 8'h80);
        chk("R5 verify pause phase", {5'd0, phase}, 8'd0);

        // R10 set and clear on the same cycle
        locked = 1; clr = 1; start = 1; tick();
        locked = 0; clr = 0; start = 0;
        chk("R10 set beats clear", status, 8'h82);
        clear_err();
        chk("R10 clear alone", status, 8'h80);

        // R1 reset in the middle of a job
        go(1'b0, 6'd8);
        repeat (5) tick();
        rst_n = 0; tick();
        chk("R1 mid-job reset status", status, 8'h80);
        chk("R1 mid-job reset phase", {5'd0, phase}, 8'd0);
        rst_n = 1; tick();
        go(1'b0, 6'd8);
        chk("R1 restart after reset", {5'd0, phase}, 8'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule